// File: doc/BRIEF.md
# Loop Port Bypass Chain

This block is a bit-level behavioural model of a ring of five bypass cells that carries one serial loop past a set of attached nodes. Each cell owns a 2:1 selector. With its active-low bypass control high, the cell puts its node in the loop and forwards that node's return stream. With the control low, the cell forwards the stream it received from the cell before it. The selector of cell n drives the node-facing output of cell n+1, and the last cell wraps round to cell 0.

A single retiming register sits just after cell 0. It stands in for a clock-recovery stage and is clocked on the bit clock. It can be taken out of the path with `rt_en_i`.

Two validity modes are supported:
- **Validity mode high:** the retimer samples node 0's return stream. A low validity flag from an external checker steers cell 0 to forward the upstream stream in place of the retimed data.
- **Validity mode low:** the retimer sits between cell 0 and node output 1, so its output always reaches node 1.

Each node output can be parked at a constant high. This happens only when a shared strobe and that node's own select line are both low.

When no cell in the ring picks a node stream and no register closes the ring, nothing drives the ring. In that case every output idles high.

Top module: `loop_bypass_chain`

## Requirements
- R1: While `rst_ni` is low the retimer register reads high. So with every cell bypassed, the retimer enabled and validity mode low, all five `node_tx_o` bits are 1 during reset.
- R2: For a cell n other than 0 with `byp_ni[n]`=1, `node_tx_o[(n+1) mod 5]` equals `node_rx_i[n]`. Cell 4 feeds output 0.
- R3: A cell with `byp_ni[n]`=0 forwards the stream at its own node output unchanged to the next cell's output. A run of bypassed cells therefore carries the nearest in-loop upstream source.
- R4: With `rt_en_i`=1, the stream leaving cell 0 toward output 1 is delayed by exactly one `clk_i` cycle. Output 1 still shows the old value before the edge.
- R5: With `rt_en_i`=0 the retimer is transparent, and output 1 follows its source with no clock edge.
- R6: With `vmode_i`=1 the retimer input is `node_rx_i[0]`. If `valid_i`=0, cell 0 forwards upstream, so `node_tx_o[1]` equals `node_tx_o[0]`. If `valid_i`=1 and `byp_ni[0]`=1, cell 0 forwards the (possibly retimed) node 0 stream.
- R7: With `vmode_i`=0, `valid_i` has no effect: output 1 always carries the retimer output of cell 0's selector.
- R8: `node_tx_o[n]` is forced to 1 only when `oe_all_i`=0 and `oe_sel_i[n]`=0. Otherwise it carries the ring value.
- R9: With every bypass control low and no register closing the ring, all outputs are 1. With the retimer enabled in validity mode low, the register recirculates and holds its last value on all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock for the retimer |
| rst_ni | input | 1 | Asynchronous active-low reset |
| node_rx_i | input | 5 | Return stream from each node |
| byp_ni | input | 5 | Active-low bypass per cell (1 = node in loop) |
| rt_en_i | input | 1 | 1 = retimer register in path, 0 = transparent |
| vmode_i | input | 1 | Validity mode select |
| valid_i | input | 1 | Validity flag from the checker of node 0's stream |
| oe_all_i | input | 1 | Shared output-enable strobe |
| oe_sel_i | input | 5 | Per-node output select |
| node_tx_o | output | 5 | Node-facing stream per cell |

## Verification
The following properties are checked on every cycle:
- In-loop cells forward their node stream one position on.
- The all-bypassed idle state holds.
- An invalid flag in validity mode makes output 1 mirror output 0.
- The flag is ignored in the other mode.
- An output differs from the ring only when both of its enable terms are low.
- The one-cycle delay through the retimer is tracked against the previous cycle's node 0 input.

The bench scenarios show the rest:
- Arbitrary bypass patterns against an independent backward-walking model.
- The absence of early change before the retiming edge.
- Recirculation of a held value when every cell is bypassed.
- The reset value.

// File: rtl/lb_pkg.sv
package lb_pkg;
  localparam int unsigned LB_CELLS = 5;
  localparam logic        LB_IDLE  = 1'b1;  // level of an undriven or parked line
endpackage

// File: rtl/lb_retime_stage.sv
module lb_retime_stage #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= RST_VAL;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/lb_ring_route.sv
module lb_ring_route #(
  parameter int unsigned N_CELLS = lb_pkg::LB_CELLS,
  parameter logic        IDLE    = lb_pkg::LB_IDLE
) (
  input  logic [N_CELLS-1:0] rx_i,
  input  logic [N_CELLS-1:0] byp_ni,
  input  logic               rt_en_i,
  input  logic               vmode_i,
  input  logic               valid_i,
  input  logic               rt_q_i,
  output logic               rt_d_o,
  output logic [N_CELLS-1:0] tx_o
);
  localparam int unsigned STEPS = 2 * N_CELLS;

  logic [N_CELLS-1:0] pick;
  logic [N_CELLS-1:0] src;
  logic               ring_reg;

  always_comb begin
    pick    = byp_ni;
    pick[0] = byp_ni[0] & (~vmode_i | valid_i);
    src     = rx_i;
    src[0]  = (vmode_i && rt_en_i) ? rt_q_i : rx_i[0];
  end

  // register closes the ring only when it sits on the cell 0 -> cell 1 link
  assign ring_reg = rt_en_i & ~vmode_i;

  // Two passes around the ring resolve every link without a combinational loop;
  // a ring with no source and no register keeps the idle level.
  always_comb begin
    logic carry;
    carry = IDLE;
    tx_o  = {N_CELLS{IDLE}};
    for (int unsigned k = 0; k < STEPS; k++) begin
      int unsigned c;
      c = (k + 1) % N_CELLS;
      if (c == 1 && ring_reg) carry = rt_q_i;
      tx_o[c] = carry;
      if (pick[c]) carry = src[c];
    end
    rt_d_o = vmode_i ? rx_i[0] : (pick[0] ? rx_i[0] : tx_o[0]);
  end
endmodule

// File: rtl/lb_out_gate.sv
module lb_out_gate #(
  parameter int unsigned N_CELLS = lb_pkg::LB_CELLS,
  parameter logic        IDLE    = lb_pkg::LB_IDLE
) (
  input  logic               oe_all_i,
  input  logic [N_CELLS-1:0] oe_sel_i,
  input  logic [N_CELLS-1:0] data_i,
  output logic [N_CELLS-1:0] tx_o
);
  for (genvar n = 0; n < N_CELLS; n++) begin : g_gate
    assign tx_o[n] = (oe_all_i | oe_sel_i[n]) ? data_i[n] : IDLE;
  end
endmodule

// File: rtl/loop_bypass_chain.sv
module loop_bypass_chain #(
  parameter int unsigned N_CELLS = lb_pkg::LB_CELLS
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_CELLS-1:0] node_rx_i,
  input  logic [N_CELLS-1:0] byp_ni,
  input  logic               rt_en_i,
  input  logic               vmode_i,
  input  logic               valid_i,
  input  logic               oe_all_i,
  input  logic [N_CELLS-1:0] oe_sel_i,
  output logic [N_CELLS-1:0] node_tx_o
);
  import lb_pkg::*;

  logic               rt_d;
  logic               rt_q;
  logic [N_CELLS-1:0] ring_tx;

  lb_retime_stage #(.RST_VAL(LB_IDLE)) i_retime (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (rt_d),
    .q_o    (rt_q)
  );

  lb_ring_route #(.N_CELLS(N_CELLS), .IDLE(LB_IDLE)) i_ring (
    .rx_i    (node_rx_i),
    .byp_ni  (byp_ni),
    .rt_en_i (rt_en_i),
    .vmode_i (vmode_i),
    .valid_i (valid_i),
    .rt_q_i  (rt_q),
    .rt_d_o  (rt_d),
    .tx_o    (ring_tx)
  );

  lb_out_gate #(.N_CELLS(N_CELLS), .IDLE(LB_IDLE)) i_gate (
    .oe_all_i (oe_all_i),
    .oe_sel_i (oe_sel_i),
    .data_i   (ring_tx),
    .tx_o     (node_tx_o)
  );

  // history qualifier for the latency check
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  for (genvar n = 1; n < N_CELLS; n++) begin : g_ast_loop
    AST_IN_LOOP_FWD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      byp_ni[n] |-> ring_tx[(n+1) % N_CELLS] == node_rx_i[n]); // R2
  end

  for (genvar n = 0; n < N_CELLS; n++) begin : g_ast_oe
    AST_OE_PARK_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (node_tx_o[n] != ring_tx[n]) |-> (!oe_all_i && !oe_sel_i[n])); // R8
  end

  AST_RT_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && rt_en_i && !vmode_i && $past(rt_en_i && !vmode_i && byp_ni[0]))
      |-> ring_tx[1] == $past(node_rx_i[0])); // R4

  AST_RT_TRANSPARENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!vmode_i && !rt_en_i && byp_ni[0]) |-> ring_tx[1] == node_rx_i[0]); // R7

  AST_INVALID_SKIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vmode_i && !valid_i) |-> ring_tx[1] == ring_tx[0]); // R6

  AST_EMPTY_RING_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byp_ni == '0 && !(rt_en_i && !vmode_i)) |-> ring_tx == '1); // R9
endmodule

// File: tb/test_loop_bypass_chain.sv
module test_loop_bypass_chain;
  localparam int N = 5;
  localparam int NVEC = 10;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [N-1:0] node_rx_i = '0;
  logic [N-1:0] byp_ni = '0;
  logic         rt_en_i = 1'b1;
  logic         vmode_i = 1'b0;
  logic         valid_i = 1'b1;
  logic         oe_all_i = 1'b1;
  logic [N-1:0] oe_sel_i = '1;
  logic [N-1:0] node_tx_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  loop_bypass_chain i_loop_bypass_chain (
    .clk_i(clk_i), .rst_ni(rst_ni), .node_rx_i(node_rx_i), .byp_ni(byp_ni),
    .rt_en_i(rt_en_i), .vmode_i(vmode_i), .valid_i(valid_i),
    .oe_all_i(oe_all_i), .oe_sel_i(oe_sel_i), .node_tx_o(node_tx_o)
  );

  // {byp, rx, vmode, valid, oe_all, oe_sel, expected tx}; retimer off
  localparam logic [22:0] VEC [NVEC] = '{
    {5'b11111, 5'b10110, 1'b0, 1'b1, 1'b1, 5'b11111, 5'b01101},  // R2
    {5'b11111, 5'b01001, 1'b0, 1'b1, 1'b1, 5'b11111, 5'b10010},  // R2 R5
    {5'b00001, 5'b11110, 1'b0, 1'b1, 1'b1, 5'b11111, 5'b00000},  // R3
    {5'b00100, 5'b11011, 1'b0, 1'b1, 1'b1, 5'b11111, 5'b00000},  // R3
    {5'b10010, 5'b01010, 1'b0, 1'b1, 1'b1, 5'b11111, 5'b11100},  // R3
    {5'b00000, 5'b00000, 1'b0, 1'b1, 1'b1, 5'b11111, 5'b11111},  // R9
    {5'b11111, 5'b00000, 1'b0, 1'b1, 1'b0, 5'b10101, 5'b01010},  // R8
    {5'b11111, 5'b00000, 1'b0, 1'b1, 1'b1, 5'b00000, 5'b00000},  // R8
    {5'b11111, 5'b00001, 1'b1, 1'b0, 1'b1, 5'b11111, 5'b00000},  // R6
    {5'b11111, 5'b00001, 1'b0, 1'b0, 1'b1, 5'b11111, 5'b00010}   // R7
  };

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%b exp=%b", req, act, exp);
    end
  endtask

  // walk backwards from each output to the nearest cell that picks its node
  function automatic logic [N-1:0] ref_tx(input logic [N-1:0] byp, input logic [N-1:0] rx,
                                          input logic vm, input logic vl);
    logic [N-1:0] r;
    for (int n = 0; n < N; n++) begin
      int c;
      bit found;
      c = (n + N - 1) % N;
      found = 1'b0;
      r[n] = 1'b1;
      for (int s = 0; s < N; s++) begin
        if (!found) begin
          if (c == 0 ? (byp[0] && (!vm || vl)) : byp[c]) begin
            r[n] = rx[c];
            found = 1'b1;
          end
          c = (c + N - 1) % N;
        end
      end
    end
    return r;
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic prev;
    logic [4:0] seq;
    // R1: reset value of the retimer seen through an all-bypassed ring
    #12;
    chk("R1 reset", node_tx_o, 5'b11111);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // table walk, retimer off
    rt_en_i = 1'b0;
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk_i);
      {byp_ni, node_rx_i, vmode_i, valid_i, oe_all_i, oe_sel_i} = VEC[i][22:5];
      #2;
      chk("R2 R3 R5 R6 R7 R8 R9 table", node_tx_o, VEC[i][4:0]);
    end

    // random patterns against the backward-walk model
    oe_all_i = 1'b1;
    oe_sel_i = '1;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk_i);
      byp_ni    = N'($urandom);
      node_rx_i = N'($urandom);
      vmode_i   = 1'($urandom);
      valid_i   = 1'($urandom);
      if (i % 16 == 0) byp_ni = '0;
      #2;
      chk("R3 random", node_tx_o, ref_tx(byp_ni, node_rx_i, vmode_i, valid_i));
    end

    // R4: one cycle latency, validity mode low
    @(negedge clk_i);
    byp_ni = '1; node_rx_i = '0; vmode_i = 1'b0; valid_i = 1'b1; rt_en_i = 1'b1;
    @(posedge clk_i);
    prev = 1'b0;
    seq = 5'b01101;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk_i);
      node_rx_i[0] = seq[i];
      valid_i = ~valid_i;  // R7: flag ignored in this mode
      #1;
      chk("R4 before edge", {4'b0, node_tx_o[1]}, {4'b0, prev});
      @(posedge clk_i);
      #1;
      chk("R4 after edge", {4'b0, node_tx_o[1]}, {4'b0, seq[i]});
      prev = seq[i];
    end

    // R6: validity mode, retimed node 0 stream then invalid skip
    @(negedge clk_i);
    vmode_i = 1'b1; valid_i = 1'b1; node_rx_i = 5'b00001;
    #1;
    chk("R6 before edge", {4'b0, node_tx_o[1]}, {4'b0, prev});
    @(posedge clk_i);
    #1;
    chk("R6 retimed", node_tx_o, 5'b00010);
    @(negedge clk_i);
    valid_i = 1'b0; node_rx_i = 5'b10001;
    #1;
    chk("R6 invalid skip", node_tx_o, 5'b00011);

    // R9: register recirculates when all cells are bypassed
    @(negedge clk_i);
    vmode_i = 1'b0; valid_i = 1'b1; byp_ni = 5'b00001; node_rx_i = 5'b11110;
    @(posedge clk_i);
    @(negedge clk_i);
    byp_ni = '0; node_rx_i = '1;
    repeat (3) @(posedge clk_i);
    #1;
    chk("R9 recirculate", node_tx_o, 5'b00000);
    @(negedge clk_i);
    vmode_i = 1'b1;
    #1;
    chk("R9 empty ring idle", node_tx_o, 5'b11111);

    // R8: parked output ignores ring activity
    @(negedge clk_i);
    vmode_i = 1'b0; rt_en_i = 1'b0; byp_ni = '1; node_rx_i = '0;
    oe_all_i = 1'b0; oe_sel_i = 5'b11101;
    #1;
    chk("R8 parked", node_tx_o, 5'b00010);
    oe_sel_i = 5'b11111;
    #1;
    chk("R8 select only", node_tx_o, 5'b00000);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule